// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block turns the two-wire differential line of a low-speed USB link into a stream of data bytes. The line inputs are assumed to be synchronized to the system clock already. The system clock runs at a fixed integer multiple of the bit rate, ten cycles per bit by default.

The receiver waits for the bus to sit idle. It then locks onto the closing edge of the sync field and places its single sample point near the middle of each bit. It undoes the NRZI line coding, drops stuffed bits and packs the decoded bits into bytes, least significant bit first. Each finished byte appears for one cycle on a valid/data pair. The end of a packet is reported with the number of bytes received. Two faults end a packet early: a stuffing violation and a buffer overrun. Each raises its own one-cycle flag.

The receiver leaves PID, CRC and endpoint handling to a later stage.

Top module: `lsusb_rx`

## Requirements
- R1: Line states are {dp,dm}: J = 01 (idle), K = 10, SE0 = 00. After reset every output is 0, and the receiver does not hunt for sync until it has seen J for a full bit time.
- R2: A J-to-K transition, followed one bit later by a K sample, marks the end of the sync field (K,J,K,J,K,J,K,K in line order). The first data bit is the bit that follows the second K.
- R3: If the sample one bit after a J-to-K transition is not K, that transition is discarded and hunting resumes. A later valid sync is still received correctly.
- R4: A decoded bit is 1 when the sample equals the previous sample and 0 when it differs. The reference for the first data bit is the last sync K. Every 8 kept bits form a byte, first bit in bit 0, and each byte raises byte_valid_o for one cycle with the byte on byte_o.
- R5: The line bit that follows six consecutive decoded 1s is a stuffed bit. It is discarded without moving the bit position, including when the run crosses a byte boundary.
- R6: A stuffed bit that shows no transition pulses stuff_err_o for one cycle. The packet is aborted without an end-of-packet pulse.
- R7: An SE0 sample at bit positions 1 to 7 pulses eop_o for one cycle, with byte_cnt_o holding the number of complete bytes. Partial bits are discarded.
- R8: An SE0 sample at bit position 0 does not end the packet. It is decoded as a 0 bit (line changed), and the sample after it is decoded against SE0.
- R9: A byte completed when BUF_BYTES bytes have already been delivered is not presented. Instead ovf_o pulses for one cycle and reception stops without eop_o.
- R10: After end-of-packet, stuffing error or overflow, hunting restarts only after the line has been J for at least one full bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_PER_BIT cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | D+ line, synchronized |
| dm_i | input | 1 | D- line, synchronized |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_o | output | 8 | Received byte |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| byte_cnt_o | output | $clog2(BUF_BYTES+1) | Bytes in the last packet, updated with eop_o |
| ovf_o | output | 1 | One-cycle buffer overflow pulse |
| stuff_err_o | output | 1 | One-cycle bit-stuffing error pulse |

## Verification
The bench checks the following cases and the failure each one would expose:
- Stuffing runs that cross byte boundaries. A receiver that slips alignment on a dropped bit returns shifted bytes.
- A lone K before the real sync. A receiver that locks on the first edge decodes garbage.
- An SE0 placed exactly on the first bit of a byte, followed by more data. A receiver that ends the packet there loses the byte.
- A stuffed bit with no transition, which must raise the error and not a byte.
- One byte more than the buffer holds. A wrong limit either drops the eighth byte or misses the overflow.
- Sync-like activity that follows an error after only half a bit of J. A receiver that re-arms too early accepts this as a packet.

// File: rtl/lsusb_rx_pkg.sv
package lsusb_rx_pkg;
  // {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CHK,
    ST_RX
  } rx_st_t;
endpackage

// File: rtl/lsusb_line_stage.sv
module lsusb_line_stage
  import lsusb_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_t ln_o,
  output line_t ln_prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ln_o      <= LN_J;
      ln_prev_o <= LN_J;
    end else begin
      ln_o      <= line_t'({dp_i, dm_i});
      ln_prev_o <= ln_o;
    end
  end
endmodule

// File: rtl/lsusb_bit_timer.sv
module lsusb_bit_timer #(
  parameter int CLK_PER_BIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_first_i,
  input  logic load_bit_i,
  output logic tick_o
);
  localparam int CW    = $clog2(2 * CLK_PER_BIT);
  // first sample lands mid-way through the bit after the detected edge
  localparam int FIRST = CLK_PER_BIT + CLK_PER_BIT / 2 - 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= CW'(CLK_PER_BIT - 1);
    else if (load_first_i)           cnt_q <= CW'(FIRST);
    else if (load_bit_i || tick_o)   cnt_q <= CW'(CLK_PER_BIT - 1);
    else                             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/lsusb_destuff.sv
module lsusb_destuff
  import lsusb_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       smp_i,
  input  line_t      ln_i,
  output logic       ev_eop_o,
  output logic       ev_err_o,
  output logic       ev_byte_o,
  output logic [7:0] byte_nxt_o
);
  line_t      prev_q;
  logic [2:0] ones_q;
  logic [2:0] pos_q;
  logic [7:0] sh_q;
  logic       bit_d, stuffed, se0;

  assign se0        = (ln_i == LN_SE0);
  assign bit_d      = (ln_i == prev_q);
  assign stuffed    = (ones_q == 3'd6);
  assign byte_nxt_o = {bit_d, sh_q[7:1]};
  assign ev_eop_o   = smp_i && se0 && (pos_q != 3'd0);
  assign ev_err_o   = smp_i && !ev_eop_o && stuffed && bit_d;
  assign ev_byte_o  = smp_i && !ev_eop_o && !stuffed && (pos_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= LN_K;
      ones_q <= '0;
      pos_q  <= '0;
      sh_q   <= '0;
    end else if (start_i) begin
      prev_q <= LN_K;
      ones_q <= '0;
      pos_q  <= '0;
      sh_q   <= '0;
    end else if (smp_i) begin
      prev_q <= ln_i;
      if (stuffed) begin
        ones_q <= '0;  // dropped, position unchanged
      end else begin
        sh_q   <= byte_nxt_o;
        pos_q  <= pos_q + 3'd1;
        ones_q <= bit_d ? ones_q + 3'd1 : 3'd0;
      end
    end
  end
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
  import lsusb_rx_pkg::*;
#(
  parameter int CLK_PER_BIT = 10,
  parameter int BUF_BYTES   = 8,
  localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dp_i,
  input  logic             dm_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_o,
  output logic             eop_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             ovf_o,
  output logic             stuff_err_o
);
  line_t      ln, ln_prev;
  rx_st_t     st_q, st_d;
  logic       tick, load_first, load_bit, smp;
  logic       ev_eop, ev_err, ev_byte;
  logic [7:0] byte_nxt;
  logic [CNT_W-1:0] cnt_q;

  lsusb_line_stage u_line (
    .clk_i, .rst_ni, .dp_i, .dm_i, .ln_o(ln), .ln_prev_o(ln_prev)
  );

  lsusb_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_tmr (
    .clk_i, .rst_ni, .load_first_i(load_first), .load_bit_i(load_bit), .tick_o(tick)
  );

  assign smp = (st_q == ST_RX) && tick;

  lsusb_destuff u_dstf (
    .clk_i, .rst_ni,
    .start_i   (st_q != ST_RX),
    .smp_i     (smp),
    .ln_i      (ln),
    .ev_eop_o  (ev_eop),
    .ev_err_o  (ev_err),
    .ev_byte_o (ev_byte),
    .byte_nxt_o(byte_nxt)
  );

  always_comb begin
    st_d       = st_q;
    load_first = 1'b0;
    load_bit   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        load_bit = (ln != LN_J);
        if (tick && ln == LN_J) st_d = ST_HUNT;
      end
      ST_HUNT: begin
        if (ln == LN_K && ln_prev == LN_J) begin
          load_first = 1'b1;
          st_d       = ST_CHK;
        end
      end
      ST_CHK: begin
        if (tick) begin
          if (ln == LN_K)      st_d = ST_RX;
          else if (ln == LN_J) st_d = ST_HUNT;
          else                 st_d = ST_IDLE;
        end
      end
      ST_RX: begin
        if (ev_eop || ev_err) st_d = ST_IDLE;
        else if (ev_byte && cnt_q == CNT_W'(BUF_BYTES)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      eop_o        <= 1'b0;
      byte_cnt_o   <= '0;
      ovf_o        <= 1'b0;
      stuff_err_o  <= 1'b0;
    end else begin
      st_q         <= st_d;
      byte_valid_o <= 1'b0;
      eop_o        <= 1'b0;
      ovf_o        <= 1'b0;
      stuff_err_o  <= 1'b0;
      if (st_q != ST_RX) cnt_q <= '0;
      if (ev_eop) begin
        eop_o      <= 1'b1;
        byte_cnt_o <= cnt_q;
      end
      if (ev_err) stuff_err_o <= 1'b1;
      if (ev_byte) begin
        if (cnt_q == CNT_W'(BUF_BYTES)) begin
          ovf_o <= 1'b1;
        end else begin
          byte_valid_o <= 1'b1;
          byte_o       <= byte_nxt;
          cnt_q        <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsusb_rx_chk.sv
module lsusb_rx_chk #(
  parameter int BUF_BYTES   = 8,
  localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dp_i,
  input logic             dm_i,
  input logic             byte_valid_o,
  input logic             eop_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input logic             ovf_o,
  input logic             stuff_err_o
);
  p_one_event_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, eop_o, ovf_o, stuff_err_o}));

  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  p_eop_on_se0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (!$past(dp_i, 2) && !$past(dm_i, 2)));

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (byte_cnt_o <= CNT_W'(BUF_BYTES)));

  p_ovf_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o && !byte_valid_o);

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |=> !stuff_err_o && !byte_valid_o && !eop_o);
endmodule

bind lsusb_rx lsusb_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dp_i(dp_i), .dm_i(dm_i),
  .byte_valid_o(byte_valid_o), .eop_o(eop_o), .byte_cnt_o(byte_cnt_o),
  .ovf_o(ovf_o), .stuff_err_o(stuff_err_o)
);

// File: tb/sim_lsusb_rx.sv
`timescale 1ns/1ps
module sim_lsusb_rx;
  localparam int BPC   = 10;
  localparam int NBUF  = 8;
  localparam int CW    = $clog2(NBUF + 1);
  localparam logic [1:0] J = 2'b01, K = 2'b10, S0 = 2'b00;
  // {byte count, bytes packed LSB byte first}
  localparam logic [35:0] VEC [6] = '{
    {4'd1, 32'h0000_0069},
    {4'd3, 32'h00FF_00AA},
    {4'd4, 32'hFFFF_FFFF},
    {4'd2, 32'h0000_7E3F},
    {4'd0, 32'h0000_0000},
    {4'd4, 32'h01FE_80FC}
  };

  logic clk = 0, rst_n = 0, dp = 0, dm = 1;
  logic byte_valid, eop, ovf, serr;
  logic [7:0] byte_q;
  logic [CW-1:0] bcnt;

  always #10 clk = ~clk;

  lsusb_rx #(.CLK_PER_BIT(BPC), .BUF_BYTES(NBUF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .byte_valid_o(byte_valid), .byte_o(byte_q), .eop_o(eop),
    .byte_cnt_o(bcnt), .ovf_o(ovf), .stuff_err_o(serr)
  );

  int checks = 0, fails = 0, cyc = 0;
  int rx_n = 0, eop_n = 0, ovf_n = 0, err_n = 0, last_cnt = 0;
  logic [7:0] rx_b [16];
  logic [1:0] cur;
  int ones;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (rx_n < 16) rx_b[rx_n] = byte_q;
      rx_n++;
    end
    if (eop) begin eop_n++; last_cnt = int'(bcnt); end
    if (ovf) ovf_n++;
    if (serr) err_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    rx_n = 0; eop_n = 0; ovf_n = 0; err_n = 0; last_cnt = -1;
  endtask

  task automatic drive(input logic [1:0] s, input int n);
    @(negedge clk);
    {dp, dm} = s;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic bit_out(input logic [1:0] s);
    drive(s, BPC);
  endtask

  task automatic send_sync();
    bit_out(K); bit_out(J); bit_out(K); bit_out(J);
    bit_out(K); bit_out(J); bit_out(K); bit_out(K);
    cur = K; ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (!b[i]) cur = (cur == J) ? K : J;
      bit_out(cur);
      ones = b[i] ? ones + 1 : 0;
      if (ones == 6) begin
        cur = (cur == J) ? K : J;
        bit_out(cur);
        ones = 0;
      end
    end
  endtask

  task automatic send_eop();
    bit_out(S0); bit_out(S0); bit_out(J); bit_out(J);
  endtask

  task automatic idle(input int bits);
    repeat (bits) bit_out(J);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!byte_valid && !eop && !ovf && !serr && bcnt == 0, "R1 reset outputs",
        {byte_valid, eop, ovf, serr}, 0);
    rst_n = 1;
    idle(3);
    chk(rx_n == 0 && eop_n == 0, "R1 quiet idle", rx_n + eop_n, 0);

    // table walk: R2 R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      int n;
      logic [31:0] d;
      n = int'(VEC[v][35:32]);
      d = VEC[v][31:0];
      clr_mon();
      send_sync();
      for (int b = 0; b < n; b++) send_byte(d[8*b +: 8]);
      send_eop();
      idle(1);
      chk(rx_n == n, "R2 R4 byte count", rx_n, n);
      for (int b = 0; b < n; b++)
        chk(rx_b[b] == d[8*b +: 8], "R4 R5 byte value", rx_b[b], d[8*b +: 8]);
      chk(eop_n == 1 && last_cnt == n, "R7 eop count", last_cnt, n);
      chk(ovf_n == 0 && err_n == 0, "R5 no fault", ovf_n + err_n, 0);
    end

    // R3: lone K before sync
    clr_mon();
    bit_out(K); bit_out(J); bit_out(J);
    send_sync(); send_byte(8'h5A); send_eop(); idle(1);
    chk(rx_n == 1 && rx_b[0] == 8'h5A, "R3 false edge then sync", rx_b[0], 8'h5A);
    chk(eop_n == 1, "R3 eop", eop_n, 1);

    // R8: SE0 at bit position 0 is data
    clr_mon();
    send_sync();
    bit_out(S0);
    bit_out(J); bit_out(J); bit_out(K); bit_out(K);
    bit_out(J); bit_out(J); bit_out(J);
    send_eop(); idle(1);
    chk(rx_n == 1 && rx_b[0] == 8'hD4, "R8 se0 at pos0", rx_b[0], 8'hD4);
    chk(eop_n == 1 && last_cnt == 1, "R8 eop after", last_cnt, 1);

    // R7: SE0 mid-byte discards partial bits
    clr_mon();
    send_sync(); send_byte(8'h33);
    bit_out(cur); bit_out(cur); bit_out(cur);
    send_eop(); idle(1);
    chk(rx_n == 1 && eop_n == 1 && last_cnt == 1, "R7 partial discarded", last_cnt, 1);

    // R6: no transition at stuffed bit
    clr_mon();
    send_sync();
    repeat (7) bit_out(K);
    // R10: only half a bit of J, then sync-like activity
    drive(J, BPC / 2);
    bit_out(K); bit_out(K);
    cur = K; ones = 0;
    send_byte(8'h00);
    send_eop(); idle(1);
    chk(err_n == 1, "R6 stuff error", err_n, 1);
    chk(rx_n == 0 && eop_n == 0, "R10 no early re-arm", rx_n + eop_n, 0);

    // R9: exact fill gives eop, one more byte overflows
    clr_mon();
    send_sync();
    for (int b = 0; b < NBUF; b++) send_byte(8'h10 + 8'(b));
    send_eop(); idle(1);
    chk(rx_n == NBUF && eop_n == 1 && last_cnt == NBUF, "R9 full buffer", last_cnt, NBUF);
    chk(ovf_n == 0, "R9 no overflow at limit", ovf_n, 0);
    clr_mon();
    send_sync();
    for (int b = 0; b <= NBUF; b++) send_byte(8'h20 + 8'(b));
    send_eop(); idle(1);
    chk(ovf_n == 1 && rx_n == NBUF, "R9 overflow", rx_n, NBUF);
    chk(eop_n == 0, "R9 no eop after overflow", eop_n, 0);

    // R10: recovers after proper idle
    clr_mon();
    send_sync(); send_byte(8'hC5); send_eop(); idle(1);
    chk(rx_n == 1 && rx_b[0] == 8'hC5 && eop_n == 1, "R10 recovery", rx_b[0], 8'hC5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule